// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block produces the fetch address for a program store of 512 words of 8 bits. On every clock edge, which is one instruction cycle, the counter loads a new value. An external decoder supplies a command code and a target address. The command picks the next value: the count plus one, a jump within the current page, a jump anywhere, a subroutine call, or a return. The store is split into 8 pages of 64 words. The page number and the offset within the page are driven as separate outputs beside the full address.

Return addresses are kept in two dedicated 9-bit save registers that shift as a last-in first-out pair. A call moves the first save register into the second, writes the return address into the first, and then jumps. A return takes the first save register as the next address and moves the second into the first. The second keeps its own value. Nesting deeper than two levels therefore loses the oldest return address, and no error is reported.

The command and target inputs are plain control pins. They are sampled on every edge and have no handshake. The decoder must present a valid command in every cycle.

Top module: `pc_stack_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the address to 0 and sets both save registers to 0. A return issued directly after reset therefore yields address 0.
- R2: Command code 0 (step) loads the address plus one in 9-bit binary. The count wraps from 511 to 0.
- R3: Command code 1 (page jump) keeps address bits [8:6] and loads bits [5:0] from `tgt[5:0]`. Bits `tgt[8:6]` are ignored.
- R4: Command code 2 (far jump) loads all 9 bits of `tgt` into the address.
- R5: Command code 3 (call) loads `tgt` into the address. It also stores the current address plus one (mod 512) in the first save register and moves the previous first save register into the second.
- R6: Command code 4 (return) loads the first save register into the address and copies the second save register into the first. The second save register keeps its value.
- R7: After three nested calls, three returns give the third return address, then the second, then the second again. The first return address is lost.
- R8: Unused command codes 5, 6 and 7 behave exactly like step.
- R9: `page` always equals address bits [8:6] and `offset` always equals address bits [5:0].
- R10: Step, page jump and far jump leave both save registers unchanged. A later return shows this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Transfer command code (0 step, 1 page jump, 2 far jump, 3 call, 4 return) |
| tgt | input | 9 | Target address for jumps and calls |
| pc | output | 9 | Current fetch address |
| page | output | 3 | Page number, address bits [8:6] |
| offset | output | 6 | Offset within the page, address bits [5:0] |

## Verification
The bench steps through the whole 512-word space and across the 511-to-0 wrap. A counter that is one bit too narrow, or that stops at the top, would break the sweep there. It tries every page with every offset, using targets whose upper bits differ from the current page. A page jump that leaked `tgt[8:6]` would land in the wrong page. Calls are nested three deep and followed by repeated returns, and a return is issued straight after reset. These runs catch a stack that shifts the wrong way on a return, or that clears the second save register, or that pushes the call address instead of the address after it. A long random command mix, including the unused codes, is then compared cycle by cycle against an arithmetic model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    PC_STEP = 3'd0,
    PC_PAGE = 3'd1,
    PC_FAR  = 3'd2,
    PC_CALL = 3'd3,
    PC_RET  = 3'd4
  } pc_cmd_e;
endpackage

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
  import pcs_pkg::*;
#(
  parameter int AW = 9,
  parameter int OW = 6
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    cmd,
  input  logic [AW-1:0] tgt,
  input  logic [AW-1:0] stack_top,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] ret_addr,
  output logic          push,
  output logic          pop
);
  localparam int PW = AW - OW;

  logic [AW-1:0] incr;
  assign incr     = cur + AW'(1);
  assign ret_addr = incr;

  always_comb begin
    nxt  = incr;
    push = 1'b0;
    pop  = 1'b0;
    case (pc_cmd_e'(cmd))
      PC_PAGE: nxt = {cur[AW-1 -: PW], tgt[OW-1:0]};
      PC_FAR:  nxt = tgt;
      PC_CALL: begin
        nxt  = tgt;
        push = 1'b1;
      end
      PC_RET: begin
        nxt = stack_top;
        pop = 1'b1;
      end
      default: nxt = incr;
    endcase
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int AW    = 9,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top
);
  logic [AW-1:0] slot [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [AW-1:0] from_above;
      logic [AW-1:0] from_below;
      if (i == 0) begin : g_first
        assign from_above = push_val;
      end else begin : g_mid_a
        assign from_above = slot[i-1];
      end
      if (i == DEPTH - 1) begin : g_last
        assign from_below = slot[i];
      end else begin : g_mid_b
        assign from_below = slot[i+1];
      end
      always_ff @(posedge clk) begin
        if (rst)       slot[i] <= '0;
        else if (push) slot[i] <= from_above;
        else if (pop)  slot[i] <= from_below;
      end
    end
  endgenerate

  assign top = slot[0];

  // R5
  push_lands_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> slot[0] == $past(push_val));

  // R6
  pop_keeps_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    pop |=> $stable(slot[DEPTH-1]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(slot[0]) && $stable(slot[DEPTH-1]));

  generate
    if (DEPTH > 1) begin : g_pop_chk
      // R6
      pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> slot[0] == $past(slot[1]));
      // R5
      push_shift_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> slot[1] == $past(slot[0]));
    end
  endgenerate
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int AW    = 9,
  parameter int OW    = 6,
  parameter int DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     cmd,
  input  logic [AW-1:0]  tgt,
  output logic [AW-1:0]  pc,
  output logic [AW-OW-1:0] page,
  output logic [OW-1:0]  offset
);
  localparam int PW = AW - OW;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] stack_top;
  logic          push;
  logic          pop;

  pcs_next_sel #(.AW(AW), .OW(OW)) u_sel (
    .cur       (pc_q),
    .cmd       (cmd),
    .tgt       (tgt),
    .stack_top (stack_top),
    .nxt       (pc_d),
    .ret_addr  (ret_addr),
    .push      (push),
    .pop       (pop)
  );

  pcs_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .push_val (ret_addr),
    .top      (stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc     = pc_q;
  assign page   = pc_q[AW-1 -: PW];
  assign offset = pc_q[OW-1:0];

  // R2
  step_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0) |=> pc == $past(pc) + AW'(1));

  // R3
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1) |=> pc[AW-1 -: PW] == $past(pc[AW-1 -: PW])
                      && pc[OW-1:0] == $past(tgt[OW-1:0]));

  // R4
  far_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2 || cmd == 3'd3) |=> pc == $past(tgt));

  // R8
  unused_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd > 3'd4) |=> pc == $past(pc) + AW'(1));

  // R6
  ret_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd4) |=> pc == $past(stack_top));
endmodule

// File: tb/sim_pc_stack_unit.sv
module sim_pc_stack_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [8:0] tgt = 9'd0;
  logic [8:0] pc;
  logic [2:0] page;
  logic [5:0] offset;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [8:0] m_pc, m_sa, m_sb;

  always #4 clk = ~clk;

  pc_stack_unit u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .tgt(tgt),
    .pc(pc), .page(page), .offset(offset)
  );

  task automatic check(input string req);
    n_vec++;
    if (pc !== m_pc) begin
      n_bad++;
      $display("FAIL %s pc actual=%0d expected=%0d", req, pc, m_pc);
    end
    // R9
    if (page !== m_pc[8:6] || offset !== m_pc[5:0]) begin
      n_bad++;
      $display("FAIL R9 page/offset actual=%0d/%0d expected=%0d/%0d",
               page, offset, m_pc[8:6], m_pc[5:0]);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [8:0] t, input string req);
    @(negedge clk);
    cmd = c;
    tgt = t;
    @(posedge clk);
    case (c)
      3'd1: m_pc = {m_pc[8:6], t[5:0]};
      3'd2: m_pc = t;
      3'd3: begin m_sb = m_sa; m_sa = m_pc + 9'd1; m_pc = t; end
      3'd4: begin m_pc = m_sa; m_sa = m_sb; end
      default: m_pc = m_pc + 9'd1;
    endcase
    #2;
    check(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd = 3'd0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 9'd0; m_sa = 9'd0; m_sb = 9'd0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check("R1");
    // R1: return right after reset gives 0
    apply(3'd4, 9'h1AB, "R1");
    // R2: full sweep including 511 -> 0 wrap
    for (int i = 0; i < 520; i++) apply(3'd0, 9'(i * 7), "R2");
    // R8: unused codes
    for (int c = 5; c < 8; c++)
      for (int i = 0; i < 4; i++) apply(3'(c), 9'h155, "R8");
    // R3/R4: every page x every offset, with conflicting upper target bits
    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 64; o++) begin
        apply(3'd2, {3'(p), 6'(63 - o)}, "R4");
        apply(3'd1, {3'(7 - p), 6'(o)}, "R3");
      end
    // R5/R6/R10: call, jumps, return
    do_reset();
    apply(3'd2, 9'd511, "R4");
    apply(3'd3, 9'd100, "R5");
    apply(3'd0, 9'd0,   "R10");
    apply(3'd1, 9'd5,   "R10");
    apply(3'd2, 9'd300, "R10");
    apply(3'd4, 9'd0,   "R6");
    // R7: three levels deep
    apply(3'd2, 9'd10,  "R4");
    apply(3'd3, 9'd50,  "R5");
    apply(3'd3, 9'd150, "R5");
    apply(3'd3, 9'd250, "R5");
    apply(3'd4, 9'd0,   "R7");
    apply(3'd4, 9'd0,   "R7");
    apply(3'd4, 9'd0,   "R7");
    apply(3'd4, 9'd0,   "R7");
    // random mix
    for (int i = 0; i < 4000; i++)
      apply(3'($urandom_range(0, 7)), 9'($urandom), "R6");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule